// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received packet bytes from a byte stream that carries valid, last-byte and error markers. It places them into buffers that software hands over through a ring of descriptors. Each descriptor carries an ownership bit, a buffer base address, a buffer size and a status word. When the block finishes with a buffer, it writes that buffer's status and returns the descriptor to software by clearing the ownership bit. The status it writes depends on where the buffer sits in the packet. The opening buffer is marked as the packet start. An inner buffer gets a blank status. The closing buffer is marked as the packet end and carries the error bits and the byte count of the whole packet.

A short internal byte FIFO covers the gap while the block waits for a descriptor. When the ring has no owned descriptor and bytes are waiting, a sticky buffer-unavailable flag is set. When a byte is lost because the FIFO is full, a sticky overflow flag is set, and the loss is also recorded in the error bits of the next packet the block finishes. Software reaches the descriptors and the buffer memory through a simple register port. A poll strobe makes the block look at the waiting descriptor at once instead of at its next periodic check. Bit-level deframing and CRC checking happen upstream, and their verdict arrives on the error input.

Top module: `rxr_ring_writer`

## Requirements
- R1: Each accepted byte is written to buffer memory at the open descriptor's base address plus the byte's offset in that buffer. Bytes are written in arrival order.
- R2: A buffer closes when it holds its stated size in bytes, or when the packet's last byte is written. On close, the descriptor's OWN bit (word 0 bit 31) is cleared and the ring index moves to the next entry. After the final entry the index returns to entry 0. No extra descriptor is consumed when a packet ends exactly at a buffer's size.
- R3: The first descriptor of a packet is returned with the start bit (word 0 bit 30) set.
- R4: A descriptor that is neither first nor last in its packet is returned with word 0 equal to zero: status bits and length all zero.
- R5: The last descriptor of a packet is returned with the end bit (word 0 bit 29) set. It carries the frame-error bit (word 0 bit 27), taken from in_err on the last byte. Its length field (word 0 bits 15:0) holds the total packet byte count across all of its buffers. A single-buffer packet has both the start bit and the end bit set.
- R6: rbu_flag is set while the block holds no owned descriptor and the FIFO is not empty. It stays set until rbu_clr is pulsed.
- R7: The FIFO holds 8 bytes. A byte that arrives while the FIFO is full is dropped and sets ovf_flag. ovf_flag stays set until ovf_clr is pulsed.
- R8: After a byte has been dropped, the next descriptor returned with the end bit also has the overflow-error bit (word 0 bit 28) set. Only that one packet is marked.
- R9: A poll pulse makes the block check the waiting descriptor's OWN bit on the next cycle. Without a poll, the block checks it every 16 cycles.
- R10: Register map. A reg_addr value with the top bit clear selects descriptor (reg_addr >> 1), with word 0 or word 1 chosen by reg_addr bit 0. With the top bit set, reg_addr selects buffer byte reg_addr[5:0]. Word 1 holds the size in bits 31:16 and the base address in bits 15:0. A write to word 0 sets OWN from bit 31 and clears the status and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present on in_data |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Byte is the last of its packet |
| in_err | input | 1 | Frame error verdict, taken on the last byte |
| poll | input | 1 | Check the waiting descriptor now |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (7) | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rbu_flag | output | 1 | Sticky buffer-unavailable flag |
| rbu_clr | input | 1 | Clears rbu_flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears ovf_flag |

## Verification
The bench builds the block with its default parameters: a four-entry ring, 64 bytes of buffer memory, an 8-byte FIFO and a 16-cycle recheck period. With only four entries, a single ten-byte packet spread over three small buffers covers all three status patterns and brings the ring index to its wrap point. A second packet then checks that the ring wraps. With only 8 bytes of FIFO, a ten-byte stall is enough to drop bytes and set the overflow flags. The short recheck period keeps the wait for an unpolled descriptor within a few dozen cycles.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [1:0] {ST_WAIT, ST_CHECK, ST_FILL} eng_state_t;

   typedef struct packed {
      logic       last;
      logic       err;
      logic [7:0] data;
   } rx_item_t;

   localparam int unsigned OWN_BIT  = 31;
   localparam int unsigned STP_BIT  = 30;
   localparam int unsigned EOP_BIT  = 29;
   localparam int unsigned EOVF_BIT = 28;
   localparam int unsigned EFRM_BIT = 27;
endpackage

// File: rtl/rxr_fifo.sv
module rxr_fifo
   import rxr_pkg::*;
#(
   parameter  int unsigned DEPTH = 8,
   localparam int unsigned PW    = $clog2(DEPTH),
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     push,
   input  rx_item_t din,
   input  logic     pop,
   output rx_item_t dout,
   output logic     empty,
   output logic     full,
   output logic [CW-1:0] count
);
   rx_item_t        store_q [DEPTH];
   logic [PW-1:0]   wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]   cnt_q;
   logic            do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CW'(DEPTH));
   assign count   = cnt_q;
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = store_q[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_any
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) begin
            store_q[wr_ptr] <= din;
            wr_ptr          <= wr_nxt;
         end
         if (do_pop) rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/rxr_desc_ring.sv
module rxr_desc_ring
   import rxr_pkg::*;
#(
   parameter  int unsigned DEPTH  = 4,
   parameter  int unsigned MEM_AW = 6,
   parameter  int unsigned LEN_W  = 16,
   localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [IDX_W-1:0]  sw_idx,
   input  logic              sw_word,
   input  logic [31:0]       sw_wdata,
   output logic [31:0]       sw_rdata,
   input  logic [IDX_W-1:0]  head_idx,
   output logic              head_own,
   output logic [MEM_AW-1:0] head_addr,
   output logic [LEN_W-1:0]  head_size,
   input  logic              cl_en,
   input  logic              cl_first,
   input  logic              cl_end,
   input  logic              cl_eovf,
   input  logic              cl_efrm,
   input  logic [LEN_W-1:0]  cl_len
);
   logic              own_q  [DEPTH];
   logic              stp_q  [DEPTH];
   logic              eop_q  [DEPTH];
   logic              eovf_q [DEPTH];
   logic              efrm_q [DEPTH];
   logic [LEN_W-1:0]  len_q  [DEPTH];
   logic [MEM_AW-1:0] addr_q [DEPTH];
   logic [LEN_W-1:0]  size_q [DEPTH];
   logic [31:0]       word0, word1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            own_q[i]  <= 1'b0;
            stp_q[i]  <= 1'b0;
            eop_q[i]  <= 1'b0;
            eovf_q[i] <= 1'b0;
            efrm_q[i] <= 1'b0;
            len_q[i]  <= '0;
            addr_q[i] <= '0;
            size_q[i] <= '0;
         end
      end else begin
         if (sw_we) begin
            if (!sw_word) begin
               own_q[sw_idx]  <= sw_wdata[OWN_BIT];
               stp_q[sw_idx]  <= 1'b0;
               eop_q[sw_idx]  <= 1'b0;
               eovf_q[sw_idx] <= 1'b0;
               efrm_q[sw_idx] <= 1'b0;
               len_q[sw_idx]  <= '0;
            end else begin
               addr_q[sw_idx] <= sw_wdata[MEM_AW-1:0];
               size_q[sw_idx] <= sw_wdata[16 +: LEN_W];
            end
         end
         if (cl_en) begin
            own_q[head_idx]  <= 1'b0;
            stp_q[head_idx]  <= cl_first;
            eop_q[head_idx]  <= cl_end;
            eovf_q[head_idx] <= cl_eovf;
            efrm_q[head_idx] <= cl_efrm;
            len_q[head_idx]  <= cl_len;
         end
      end
   end

   assign head_own  = own_q[head_idx];
   assign head_addr = addr_q[head_idx];
   assign head_size = size_q[head_idx];

   always_comb begin
      word0 = 32'(len_q[sw_idx]);
      word0[OWN_BIT]  = own_q[sw_idx];
      word0[STP_BIT]  = stp_q[sw_idx];
      word0[EOP_BIT]  = eop_q[sw_idx];
      word0[EOVF_BIT] = eovf_q[sw_idx];
      word0[EFRM_BIT] = efrm_q[sw_idx];
      word1 = (32'(size_q[sw_idx]) << 16) | 32'(addr_q[sw_idx]);
      sw_rdata = sw_word ? word1 : word0;
   end
endmodule

// File: rtl/rxr_bufmem.sv
module rxr_bufmem #(
   parameter  int unsigned BYTES = 64,
   localparam int unsigned AW    = $clog2(BYTES)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] mem_q [BYTES];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
   import rxr_pkg::*;
#(
   parameter  int unsigned DEPTH       = 4,
   parameter  int unsigned MEM_AW      = 6,
   parameter  int unsigned LEN_W       = 16,
   parameter  int unsigned POLL_PERIOD = 16,
   localparam int unsigned IDX_W       = $clog2(DEPTH),
   localparam int unsigned TMR_W       = $clog2(POLL_PERIOD)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              poll,
   input  logic              drop,
   input  logic              fifo_empty,
   input  rx_item_t          fifo_item,
   output logic              fifo_pop,
   output logic [IDX_W-1:0]  idx,
   input  logic              head_own,
   input  logic [MEM_AW-1:0] head_addr,
   input  logic [LEN_W-1:0]  head_size,
   output logic              cl_en,
   output logic              cl_first,
   output logic              cl_end,
   output logic              cl_eovf,
   output logic              cl_efrm,
   output logic [LEN_W-1:0]  cl_len,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_waddr,
   output logic [7:0]        mem_wdata,
   output logic              rbu_set
);
   eng_state_t        state_q;
   logic [TMR_W-1:0]  tmr_q;
   logic [IDX_W-1:0]  idx_q, idx_nxt;
   logic [MEM_AW-1:0] base_q;
   logic [LEN_W-1:0]  size_q, off_q, pkt_len_q;
   logic              first_q, ovf_pend_q;
   logic              close_now;

   assign idx       = idx_q;
   assign idx_nxt   = (idx_q == IDX_W'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
   assign fifo_pop  = (state_q == ST_FILL) && !fifo_empty;
   assign close_now = fifo_item.last ||
                      (({1'b0, off_q} + 1'b1) >= {1'b0, size_q});
   assign cl_en     = fifo_pop && close_now;
   assign cl_first  = first_q;
   assign cl_end    = fifo_item.last;
   assign cl_eovf   = fifo_item.last && ovf_pend_q;
   assign cl_efrm   = fifo_item.last && fifo_item.err;
   assign cl_len    = fifo_item.last ? pkt_len_q + 1'b1 : '0;
   assign mem_we    = fifo_pop;
   assign mem_waddr = base_q + off_q[MEM_AW-1:0];
   assign mem_wdata = fifo_item.data;
   assign rbu_set   = (state_q == ST_WAIT) && !fifo_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_WAIT;
         tmr_q      <= '0;
         idx_q      <= '0;
         base_q     <= '0;
         size_q     <= '0;
         off_q      <= '0;
         pkt_len_q  <= '0;
         first_q    <= 1'b1;
         ovf_pend_q <= 1'b0;
      end else begin
         if (drop)                          ovf_pend_q <= 1'b1;
         else if (cl_en && fifo_item.last)  ovf_pend_q <= 1'b0;

         unique case (state_q)
            ST_WAIT: begin
               if (poll || tmr_q == TMR_W'(POLL_PERIOD - 1)) begin
                  state_q <= ST_CHECK;
                  tmr_q   <= '0;
               end else begin
                  tmr_q   <= tmr_q + 1'b1;
               end
            end
            ST_CHECK: begin
               if (head_own) begin
                  state_q <= ST_FILL;
                  base_q  <= head_addr;
                  size_q  <= head_size;
                  off_q   <= '0;
               end else begin
                  state_q <= ST_WAIT;
                  tmr_q   <= '0;
               end
            end
            ST_FILL: begin
               if (fifo_pop) begin
                  if (close_now) begin
                     state_q <= ST_CHECK;
                     idx_q   <= idx_nxt;
                     off_q   <= '0;
                     if (fifo_item.last) begin
                        pkt_len_q <= '0;
                        first_q   <= 1'b1;
                     end else begin
                        pkt_len_q <= pkt_len_q + 1'b1;
                        first_q   <= 1'b0;
                     end
                  end else begin
                     off_q     <= off_q + 1'b1;
                     pkt_len_q <= pkt_len_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_WAIT;
         endcase
      end
   end
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
   import rxr_pkg::*;
#(
   parameter  int unsigned RING_DEPTH  = 4,
   parameter  int unsigned MEM_BYTES   = 64,
   parameter  int unsigned FIFO_DEPTH  = 8,
   parameter  int unsigned POLL_PERIOD = 16,
   parameter  int unsigned LEN_W       = 16,
   localparam int unsigned IDX_W       = $clog2(RING_DEPTH),
   localparam int unsigned MEM_AW      = $clog2(MEM_BYTES),
   localparam int unsigned SEL_W       = (IDX_W + 1 > MEM_AW) ? IDX_W + 1 : MEM_AW,
   localparam int unsigned REG_AW      = SEL_W + 1,
   localparam int unsigned FCW         = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              in_last,
   input  logic              in_err,
   input  logic              poll,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              rbu_flag,
   input  logic              rbu_clr,
   output logic              ovf_flag,
   input  logic              ovf_clr
);
   generate
      if (RING_DEPTH < 2)                       begin : g_chk_ring  $error("RING_DEPTH must be at least 2"); end
      if ((MEM_BYTES & (MEM_BYTES - 1)) != 0)   begin : g_chk_mem   $error("MEM_BYTES must be a power of two"); end
      if (MEM_AW > 16 || LEN_W > 16)            begin : g_chk_field $error("address and length fields are limited to 16 bits"); end
      if (LEN_W < MEM_AW)                       begin : g_chk_len   $error("LEN_W must cover the buffer address width"); end
      if (FIFO_DEPTH < 2)                       begin : g_chk_fifo  $error("FIFO_DEPTH must be at least 2"); end
      if (POLL_PERIOD < 2)                      begin : g_chk_poll  $error("POLL_PERIOD must be at least 2"); end
   endgenerate

   rx_item_t          f_din, f_dout;
   logic              f_empty, f_full, f_pop;
   logic [FCW-1:0]    f_count;
   logic              drop;
   logic [IDX_W-1:0]  idx;
   logic              head_own;
   logic [MEM_AW-1:0] head_addr;
   logic [LEN_W-1:0]  head_size;
   logic              cl_en, cl_first, cl_end, cl_eovf, cl_efrm;
   logic [LEN_W-1:0]  cl_len;
   logic              mem_we;
   logic [MEM_AW-1:0] mem_waddr;
   logic [7:0]        mem_wdata, mem_rdata;
   logic              rbu_set;
   logic              is_buf, sw_we;
   logic [31:0]       desc_rdata;
   logic              rbu_q, ovf_q;
   logic              unused_addr;

   assign f_din       = '{last: in_last, err: in_err, data: in_data};
   assign drop        = in_valid && f_full;
   assign is_buf      = reg_addr[REG_AW-1];
   assign sw_we       = reg_wr && !is_buf;
   assign reg_rdata   = is_buf ? {24'd0, mem_rdata} : desc_rdata;
   assign unused_addr = ^reg_addr;

   rxr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(in_valid), .din(f_din), .pop(f_pop),
      .dout(f_dout), .empty(f_empty), .full(f_full), .count(f_count)
   );

   rxr_desc_ring #(.DEPTH(RING_DEPTH), .MEM_AW(MEM_AW), .LEN_W(LEN_W)) u_ring (
      .clk(clk), .rst_n(rst_n),
      .sw_we(sw_we), .sw_idx(reg_addr[IDX_W:1]), .sw_word(reg_addr[0]),
      .sw_wdata(reg_wdata), .sw_rdata(desc_rdata),
      .head_idx(idx), .head_own(head_own), .head_addr(head_addr), .head_size(head_size),
      .cl_en(cl_en), .cl_first(cl_first), .cl_end(cl_end), .cl_eovf(cl_eovf),
      .cl_efrm(cl_efrm), .cl_len(cl_len)
   );

   rxr_bufmem #(.BYTES(MEM_BYTES)) u_mem (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr(reg_addr[MEM_AW-1:0]), .rdata(mem_rdata)
   );

   rxr_engine #(.DEPTH(RING_DEPTH), .MEM_AW(MEM_AW), .LEN_W(LEN_W),
                .POLL_PERIOD(POLL_PERIOD)) u_eng (
      .clk(clk), .rst_n(rst_n), .poll(poll), .drop(drop),
      .fifo_empty(f_empty), .fifo_item(f_dout), .fifo_pop(f_pop), .idx(idx),
      .head_own(head_own), .head_addr(head_addr), .head_size(head_size),
      .cl_en(cl_en), .cl_first(cl_first), .cl_end(cl_end), .cl_eovf(cl_eovf),
      .cl_efrm(cl_efrm), .cl_len(cl_len),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .rbu_set(rbu_set)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rbu_q <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         if (rbu_set)      rbu_q <= 1'b1;
         else if (rbu_clr) rbu_q <= 1'b0;
         if (drop)         ovf_q <= 1'b1;
         else if (ovf_clr) ovf_q <= 1'b0;
      end
   end

   assign rbu_flag = rbu_q;
   assign ovf_flag = ovf_q;
endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk #(
   parameter int unsigned FIFO_DEPTH = 8,
   parameter int unsigned FCW        = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic [FCW-1:0] f_count,
   input logic           drop,
   input logic           cl_en,
   input logic           head_own,
   input logic           rbu_set,
   input logic           rbu_flag,
   input logic           rbu_clr,
   input logic           ovf_flag,
   input logic           ovf_clr
);
   p_fifo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      32'(f_count) <= FIFO_DEPTH);

   p_drop_sets_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> ovf_flag);

   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag && !ovf_clr |=> ovf_flag);

   p_rbu_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rbu_flag && !rbu_clr |=> rbu_flag);

   p_rbu_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rbu_clr && !rbu_set |=> !rbu_flag);

   p_close_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cl_en |-> head_own);
endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.FIFO_DEPTH(FIFO_DEPTH), .FCW(FCW)) u_chk (
   .clk(clk), .rst_n(rst_n), .f_count(f_count), .drop(drop), .cl_en(cl_en),
   .head_own(head_own), .rbu_set(rbu_set), .rbu_flag(rbu_flag), .rbu_clr(rbu_clr),
   .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
);

// File: tb/sim_rxr_ring_writer.sv
module sim_rxr_ring_writer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0, poll = 1'b0;
   logic [7:0]  in_data = '0;
   logic        reg_wr = 1'b0;
   logic [6:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        rbu_flag, ovf_flag;
   logic        rbu_clr = 1'b0, ovf_clr = 1'b0;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   typedef struct { int addr; logic [31:0] val; string tag; } exp_t;
   exp_t sb[$];

   localparam logic [31:0] OWN = 32'h8000_0000;

   always #4 clk = ~clk;

   rxr_ring_writer u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_err(in_err), .poll(poll), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rbu_flag(rbu_flag), .rbu_clr(rbu_clr), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
   );

   task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(int addr, logic [31:0] data);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 7'(addr); reg_wdata = data;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(int addr, output logic [31:0] data);
      @(negedge clk);
      reg_addr = 7'(addr);
      #1 data = reg_rdata;
   endtask

   task automatic expect_word(int addr, logic [31:0] val, string tag);
      sb.push_back('{addr: addr, val: val, tag: tag});
   endtask

   // monitor: pops the scoreboard and compares with what the design stored
   task automatic drain();
      logic [31:0] v;
      while (sb.size() > 0) begin
         exp_t e = sb.pop_front();
         rd(e.addr, v);
         check(v, e.val, e.tag);
      end
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
   endtask

   // driver: sends n bytes, expects the first nexp of them at buffer base..
   task automatic send(int n, int start, bit lst, bit err, int base, int nexp);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = 8'(start + i);
         in_last  = lst && (i == n - 1);
         in_err   = err && (i == n - 1);
         if (i < nexp) expect_word(64 + base + i, 32'(8'(start + i)), "R1");
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
   endtask

   function automatic logic [31:0] w1(int size, int addr);
      return {16'(size), 16'(addr)};
   endfunction

   initial begin
      #(8 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(0, v); check(v, 32'h0, "R10 reset word0");
      check(32'(rbu_flag), 0, "R6 reset rbu");
      check(32'(ovf_flag), 0, "R7 reset ovf");

      // arm four descriptors
      wr(1, w1(8, 0));  wr(0, OWN);
      wr(3, w1(4, 8));  wr(2, OWN);
      wr(5, w1(4, 12)); wr(4, OWN);
      wr(7, w1(4, 16)); wr(6, OWN);
      rd(3, v); check(v, w1(4, 8), "R10 word1 readback");
      pulse(poll);

      // single-buffer packet with frame error
      send(3, 8'h10, 1, 1, 0, 3);
      expect_word(0, 32'h6800_0003, "R5 single start+end+frame err");
      // ten-byte packet over three 4-byte buffers
      send(10, 8'h20, 1, 0, 8, 10);
      expect_word(2, 32'h4000_0000, "R3 first buffer");
      expect_word(4, 32'h0000_0000, "R4 middle buffer");
      expect_word(6, 32'h2000_000A, "R5 last buffer total length");
      repeat (20) @(negedge clk);
      drain();
      check(32'(rbu_flag), 0, "R6 no rbu while buffers were owned");

      // ring wrapped to entry 0, not owned: data waits, rbu set
      send(2, 8'h40, 1, 0, 24, 2);
      repeat (3) @(negedge clk);
      check(32'(rbu_flag), 1, "R6 rbu set");
      wr(1, w1(8, 24)); wr(0, OWN);
      repeat (20) @(negedge clk);
      expect_word(0, 32'h6000_0002, "R2 R9 wrap and periodic recheck");
      drain();
      pulse(rbu_clr);
      check(32'(rbu_flag), 0, "R6 rbu cleared");

      // overflow: entry 1 not owned, 10 bytes into an 8-byte FIFO
      send(10, 8'h50, 0, 0, 40, 8);
      check(32'(ovf_flag), 1, "R7 overflow flag");
      check(32'(rbu_flag), 1, "R6 rbu during stall");
      wr(3, w1(16, 40)); wr(2, OWN);
      pulse(poll);
      repeat (12) @(negedge clk);
      rd(2, v); check(v, OWN, "R2 partly filled buffer still owned");
      send(2, 8'h60, 1, 0, 48, 2);
      repeat (10) @(negedge clk);
      expect_word(2, 32'h7000_000A, "R8 overflow recorded in next packet");
      drain();
      pulse(ovf_clr);
      check(32'(ovf_flag), 0, "R7 ovf cleared");

      // poll gives a prompt check; packet fills buffer exactly
      send(3, 8'h70, 1, 0, 52, 3);
      wr(5, w1(3, 52)); wr(4, OWN);
      pulse(poll);
      repeat (6) @(negedge clk);
      rd(4, v); check(v, 32'h6000_0003, "R9 R8 polled, no stale overflow");
      rd(6, v); check(v, 32'h2000_000A, "R2 exact fill consumes one entry");
      drain();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule